// File: doc/BRIEF.md
# Audio Serial Port Transmitter

This block turns parallel audio samples into a serial bit stream. It generates its own bit clock and frame sync from the system clock through a programmable divider. Each frame is 64 bit clocks long and splits into two halves of 32 bit clocks. The first half carries the left channel and the second half carries the right channel.

Three framings are available:
- DSP style, where a one-bit frame-sync pulse comes just before the data.
- I2S, where data starts one bit clock late and the frame sync is low for the left channel.
- Left-justified sample pair, where data starts on the frame-sync edge and the frame sync is high for the left channel.

The word length is programmable, and the bit order can be MSB-first or LSB-first.

Samples arrive on a valid/ready port with a channel tag. At the start of each half-frame's data, the block takes the waiting sample only if its tag matches the channel of that half. If no sample is taken, the half carries zeros and a one-cycle miss pulse is raised. A sample with the wrong tag stays on the port until a half of its own channel comes round.

Top module: `aud_ser_tx`

## Requirements
- R1: `sclk` stays in each level for `clk_div`+1 system clocks, so one bit period lasts 2×(`clk_div`+1) clocks. `sdata` and `fsync` change only in the clock cycle in which `sclk` falls. The first falling edge after reset starts bit 0 of a frame.
- R2: A frame is 64 bit periods long. Bits 0–31 form the left half, which takes tag `s_chan`=0. Bits 32–63 form the right half, which takes tag 1.
- R3: When `mode`=2'b10 (left-justified), `fsync` is 1 for the whole left half and 0 for the right half. The first data bit of each half is at position 0 of that half.
- R4: When `mode`=2'b01 (I2S), `fsync` is 0 for the left half and 1 for the right half. The first data bit of each half is at position 1. With a 32-bit word, the last bit of a word is sent at position 0 of the following half.
- R5: When `mode`=2'b00 (DSP style), `fsync` is 1 only at position 0 of each half. The first data bit is at position 1.
- R6: The effective word length is `word_len` clamped to the range 3..32 in DSP mode, and to the range 8..32 in the other two modes. Positions after the word are driven 0, and sample bits above the word length are never sent.
- R7: When `msb_first`=1, bit (length−1) of the sample is sent first, going down to bit 0. When `msb_first`=0, bit 0 is sent first, going up.
- R8: `s_ready` is 1 only in the clock cycle of the falling `sclk` edge that opens a half's first data bit, and only when `s_chan` equals that half's channel. A sample is consumed when `s_valid` and `s_ready` are both 1.
- R9: If no sample is consumed at that point, the half sends only zeros and `slot_miss` is 1 for that one clock cycle. A waiting sample whose tag does not match is kept, and it is taken at the next half of its own channel.
- R10: While `rst` is 1, `sclk`, `fsync`, `sdata` and `s_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Framing: 00 DSP style, 01 I2S, 10 left-justified |
| msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| word_len | input | 6 | Requested word length in bits |
| clk_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted this cycle |
| s_data | input | DW | Sample value, right-aligned |
| s_chan | input | 1 | Channel tag: 0 left, 1 right |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data, changes on the falling `sclk` edge |
| slot_miss | output | 1 | One-cycle pulse when a half starts without a sample |

## Verification
Two events can fall in the same clock cycle.

The first pair is a half-frame load and a rejection. This happens when a sample with the wrong tag waits on the port at the slot start. The bench provokes it by feeding a run of two right-channel samples in a row. It then judges the result by three things:
- the zeros in the skipped left half;
- the miss count over the run;
- the delayed sample turning up intact in the next right half.

The second pair occurs in I2S mode with 32-bit words. There, the last bit of one word and the load of the next word meet at the same half boundary. The bench compares every captured position, including position 0, against an arithmetic model of word placement.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        MODE_DSP = 2'd0,
        MODE_I2S = 2'd1,
        MODE_LJ  = 2'd2,
        MODE_RSV = 2'd3
    } tx_mode_e;

    // Slot events produced by the framer for the shifter and handshake.
    typedef struct packed {
        logic fall;        // sclk falls this cycle
        logic load;        // first data bit of a half starts this cycle
        logic want_right;  // channel of the half being entered
    } slot_ev_t;

    // Clamp a requested word length to the range the framing allows.
    function automatic int unsigned eff_len(tx_mode_e m, int unsigned req, int unsigned maxw);
        int unsigned lo;
        lo = (m == MODE_I2S || m == MODE_LJ) ? 8 : 3;
        if (req < lo)
            return lo;
        if (req > maxw)
            return maxw;
        return req;
    endfunction

    // Data starts one bit late in every framing except left-justified.
    function automatic logic late_start(tx_mode_e m);
        return (m != MODE_LJ);
    endfunction

    // Frame-sync level for a bit position, given its half and whether it is position 0.
    function automatic logic fsync_level(tx_mode_e m, logic right_half, logic pos_zero);
        case (m)
            MODE_LJ:  return ~right_half;
            MODE_I2S: return right_half;
            default:  return pos_zero;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             sclk_q;
    logic             tick;

    assign tick = (cnt == div);
    assign fall = tick & sclk_q;
    assign sclk = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
    import aud_tx_pkg::*;
#(
    parameter int HALF_BITS = 32,
    localparam int HALF_W   = $clog2(HALF_BITS),
    localparam int POS_W    = HALF_W + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  tx_mode_e mode,
    input  logic     fall,
    output slot_ev_t ev,
    output logic     fsync
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt;
    logic             fs_q;

    assign nxt = pos + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '1;
            fs_q <= 1'b0;
        end else if (fall) begin
            pos  <= nxt;
            fs_q <= fsync_level(mode, nxt[POS_W-1], nxt[HALF_W-1:0] == '0);
        end
    end

    always_comb begin
        ev.fall       = fall;
        ev.load       = fall && (nxt[HALF_W-1:0] == HALF_W'(late_start(mode)));
        ev.want_right = nxt[POS_W-1];
    end

    assign fsync = fs_q;
endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
    import aud_tx_pkg::*;
#(
    parameter int DW     = 32,
    localparam int LEN_W = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_ev_t         ev,
    input  logic             take,
    input  logic [DW-1:0]    din,
    input  logic [LEN_W-1:0] len,
    input  logic             msb_first,
    output logic             sdata
);
    logic [DW-1:0]    sh;
    logic [LEN_W-1:0] rem;
    logic             bit_q;
    logic [DW-1:0]    msb_al;

    // Left-align the word so its top bit sits at DW-1.
    assign msb_al = din << (LEN_W'(DW) - len);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            rem   <= '0;
            bit_q <= 1'b0;
        end else if (ev.fall) begin
            if (ev.load) begin
                if (take) begin
                    rem <= len - 1'b1;
                    if (msb_first) begin
                        bit_q <= msb_al[DW-1];
                        sh    <= msb_al << 1;
                    end else begin
                        bit_q <= din[0];
                        sh    <= din >> 1;
                    end
                end else begin
                    sh    <= '0;
                    rem   <= '0;
                    bit_q <= 1'b0;
                end
            end else if (rem != '0) begin
                rem <= rem - 1'b1;
                if (msb_first) begin
                    bit_q <= sh[DW-1];
                    sh    <= sh << 1;
                end else begin
                    bit_q <= sh[0];
                    sh    <= sh >> 1;
                end
            end else begin
                bit_q <= 1'b0;
            end
        end
    end

    assign sdata = bit_q;
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DW        = 32,
    parameter int HALF_BITS = 32,
    localparam int LEN_W    = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             msb_first,
    input  logic [LEN_W-1:0] word_len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [DW-1:0]    s_data,
    input  logic             s_chan,
    output logic             sclk,
    output logic             fsync,
    output logic             sdata,
    output logic             slot_miss
);
    tx_mode_e         mode_e;
    logic [LEN_W-1:0] len;
    logic             fall;
    slot_ev_t         ev;
    logic             take;

    assign mode_e = tx_mode_e'(mode);
    assign len    = LEN_W'(eff_len(mode_e, 32'(word_len), DW));

    aud_tx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .div  (clk_div),
        .sclk (sclk),
        .fall (fall)
    );

    aud_tx_framer #(.HALF_BITS(HALF_BITS)) u_frm (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_e),
        .fall  (fall),
        .ev    (ev),
        .fsync (fsync)
    );

    assign s_ready   = ev.load && (s_chan == ev.want_right);
    assign take      = s_valid && s_ready;
    assign slot_miss = ev.load && !take;

    aud_tx_shifter #(.DW(DW)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .take      (take),
        .din       (s_data),
        .len       (len),
        .msb_first (msb_first),
        .sdata     (sdata)
    );
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic fsync,
    input logic sdata,
    input logic s_valid,
    input logic s_ready,
    input logic slot_miss
);
    // R1: serial data moves only with a falling bit clock
    p_data_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> $fell(sclk));

    // R1: frame sync moves only with a falling bit clock
    p_fsync_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync) |-> $fell(sclk));

    // R8: acceptance only in the cycle the bit clock falls
    p_ready_at_edge_r8: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> $fell(sclk));

    // R9: a miss pulse coincides with a slot start
    p_miss_at_edge_r9: assert property (@(posedge clk) disable iff (rst)
        slot_miss |=> $fell(sclk));

    // R9: a miss and a handshake never share a cycle
    p_miss_no_take_r9: assert property (@(posedge clk) disable iff (rst)
        slot_miss |-> !(s_valid && s_ready));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .fsync     (fsync),
    .sdata     (sdata),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .slot_miss (slot_miss)
);

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int DIV_W      = 8;
    localparam int WDOG       = 150000;

    logic             clk;
    logic             rst;
    logic [1:0]       mode;
    logic             msb_first;
    logic [5:0]       word_len;
    logic [DIV_W-1:0] clk_div;
    logic             s_valid;
    logic             s_ready;
    logic [DW-1:0]    s_data;
    logic             s_chan;
    logic             sclk;
    logic             fsync;
    logic             sdata;
    logic             slot_miss;

    aud_ser_tx #(.DIV_W(DIV_W), .DW(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .msb_first (msb_first),
        .word_len  (word_len),
        .clk_div   (clk_div),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .s_chan    (s_chan),
        .sclk      (sclk),
        .fsync     (fsync),
        .sdata     (sdata),
        .slot_miss (slot_miss)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int miss_cnt;
    bit cap_done;

    logic [31:0] sd   [0:7];
    bit          sc   [0:7];
    int          n_smp;
    logic [31:0] capd [0:7];
    logic [31:0] capf [0:7];

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    always @(posedge clk) cycles++;

    always @(negedge clk)
        if (!rst && !cap_done && slot_miss) miss_cnt++;

    initial begin
        wait (cycles >= WDOG);
        fails++;
        checks++;
        $display("FAIL R8 watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic int clamp_len(int m, int wl);
        int lo;
        lo = (m == 0) ? 3 : 8;
        if (wl < lo) return lo;
        if (wl > 32) return 32;
        return wl;
    endfunction

    // j-th transmitted bit of word w
    function automatic bit txb(logic [31:0] w, int le, bit msb, int j);
        return msb ? w[le - 1 - j] : w[j];
    endfunction

    task automatic fill(int n, int seed);
        for (int k = 0; k < 8; k++) begin
            sd[k] = (32'h9E3779B9 * (k + seed + 1)) ^ 32'h5A5A0FF0;
            sc[k] = k[0];
        end
        n_smp = n;
    endtask

    task automatic do_reset(int m, int wl, bit msb, int div);
        @(negedge clk);
        rst       = 1'b1;
        mode      = 2'(m);
        word_len  = 6'(wl);
        msb_first = msb;
        clk_div   = DIV_W'(div);
        s_valid   = 1'b0;
        s_data    = '0;
        s_chan    = 1'b0;
        cap_done  = 1'b1;
        repeat (3) @(negedge clk);
        // R10: everything quiet in reset
        check({sclk, fsync, sdata, s_ready} == 4'b0, "R10 reset outputs",
              {28'd0, sclk, fsync, sdata, s_ready}, 32'd0);
        miss_cnt = 0;
        cap_done = 1'b0;
        rst      = 1'b0;
    endtask

    task automatic feeder();
        int k;
        k = 0;
        s_valid = (k < n_smp);
        s_data  = sd[0];
        s_chan  = sc[0];
        while (!cap_done) begin
            @(negedge clk);
            if (s_valid && s_ready) begin
                @(posedge clk);
                #1;
                k++;
                s_valid = (k < n_smp);
                if (k < 8) begin
                    s_data = sd[k];
                    s_chan = sc[k];
                end
            end
        end
        s_valid = 1'b0;
    endtask

    task automatic capture(int frames);
        for (int r = 0; r <= 64 * frames; r++) begin
            @(posedge sclk);
            @(negedge clk);
            if (r > 0) begin
                capd[(r - 1) / 32][(r - 1) % 32] = sdata;
                capf[(r - 1) / 32][(r - 1) % 32] = fsync;
            end
        end
        cap_done = 1'b1;
    endtask

    task automatic run_cfg(int m, int wl, bit msb, int div, int frames);
        int          le, s, p, exp_miss;
        logic [31:0] w   [0:7];
        bit          has [0:7];
        logic [31:0] ed, ef;
        string       tag;
        do_reset(m, wl, msb, div);
        fork
            feeder();
            capture(frames);
        join
        le  = clamp_len(m, wl);
        s   = (m == 2) ? 0 : 1;
        tag = (m == 2) ? "R3" : (m == 1) ? "R4" : "R5";
        p = 0;
        exp_miss = 0;
        for (int g = 0; g < 2 * frames; g++) begin
            if (p < n_smp && sc[p] == g[0]) begin
                w[g] = sd[p];
                has[g] = 1'b1;
                p++;
            end else begin
                w[g] = '0;
                has[g] = 1'b0;
                exp_miss++;
            end
        end
        for (int g = 0; g < 2 * frames; g++) begin
            ed = '0;
            ef = '0;
            for (int i = 0; i < 32; i++) begin
                if (i >= s && i - s < le && has[g])
                    ed[i] = txb(w[g], le, msb, i - s);
                else if (i == 0 && s == 1 && le == 32 && g > 0 && has[g - 1])
                    ed[i] = txb(w[g - 1], le, msb, 31);
                if (m == 2)      ef[i] = !g[0];
                else if (m == 1) ef[i] = g[0];
                else             ef[i] = (i == 0);
            end
            check(capd[g] == ed, $sformatf("%s data half %0d mode %0d len %0d msb %0d (R6,R7)",
                  tag, g, m, wl, msb), capd[g], ed);
            check(capf[g] == ef, $sformatf("%s frame sync half %0d (R2)", tag, g), capf[g], ef);
        end
        check(miss_cnt == exp_miss, "R9 miss pulses", miss_cnt, exp_miss);
    endtask

    task automatic period_check(int div);
        int t0, t1;
        n_smp = 0;
        do_reset(0, 16, 1'b1, div);
        @(posedge sclk);
        @(negedge clk);
        t0 = cycles;
        @(posedge sclk);
        @(negedge clk);
        t1 = cycles;
        cap_done = 1'b1;
        check(t1 - t0 == 2 * (div + 1), "R1 bit period", t1 - t0, 2 * (div + 1));
    endtask

    initial begin
        int lens [6];
        int seed;
        lens = '{3, 8, 13, 24, 31, 32};
        rst = 1'b1;
        cap_done = 1'b1;
        seed = 0;
        // R3 R4 R5 R6 R7: sweep framings, lengths and bit orders
        for (int m = 0; m < 3; m++)
            for (int li = 0; li < 6; li++)
                for (int b = 0; b < 2; b++) begin
                    seed++;
                    fill(4, seed);
                    run_cfg(m, lens[li], b[0], 0, 2);
                end
        // R6: clamping outside the legal ranges
        fill(4, 77); run_cfg(0, 1, 1'b1, 0, 2);
        fill(4, 78); run_cfg(2, 40, 1'b0, 0, 2);
        fill(4, 79); run_cfg(1, 5, 1'b1, 0, 2);
        // R8 R9: mismatched tag held back, then underrun at the end
        fill(4, 91);
        sc[0] = 1'b0; sc[1] = 1'b1; sc[2] = 1'b1; sc[3] = 1'b0;
        run_cfg(2, 16, 1'b1, 0, 3);
        fill(4, 92);
        sc[0] = 1'b1; sc[1] = 1'b0; sc[2] = 1'b1; sc[3] = 1'b0;
        run_cfg(1, 32, 1'b1, 0, 2);
        // R1: slower bit clock, period and content
        fill(4, 93); run_cfg(0, 16, 1'b0, 2, 1);
        period_check(2);
        period_check(0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule